// File: doc/BRIEF.md
# Packed Colormap Write Sequencer

This block is the register front end of a palette RAM. Every color index owns three component bytes, stored as red, green and blue. A bus master first writes a starting index to the address register. It then sends bytes to the data register, and the block places them into successive components. After the blue component of an index, the block moves on to the next index by itself, so software never has to rewrite the address between entries.

The block has two modes. In packed mode a single 32-bit data write delivers four component bytes, most significant byte first, and those bytes run across entry boundaries. The block therefore keeps the component phase from one bus write to the next. Because it commits one byte per clock, it pulls its ready output low while it drains a word. In narrow mode only the top byte of each bus word counts, and each write delivers one component.

An indirect pointer, which is the last value written to the address register, decides what a control-register write loads: the command register or the read mask. A combinational readback port returns any entry as a 24-bit value so that the palette contents can be checked.

Top module: `pal_pack_seq`

## Requirements
- R1: After reset, ready is 1, the command register and the read mask are 0, and every palette entry reads back as 0.
- R2: A write to offset 0 (address) sets the palette index and resets the component phase to red. The index is taken from bits 7:0 in packed mode and from bits 31:24 in narrow mode. Ready stays 1 in the following cycle.
- R3: In packed mode a write to offset 1 (data) stores bits 31:24, 23:16, 15:8 and 7:0, in that order, into consecutive components. The phase carries over between writes: from index 0, the first word fills R0 G0 B0 R1 and the second fills G1 B1 R2 G2.
- R4: In narrow mode a data write stores only bits 31:24, into exactly one component. Bits 23:0 have no effect.
- R5: The index advances by one after a blue component is stored, and it wraps from 255 to 0. Readback returns {red[23:16], green[15:8], blue[7:0]}.
- R6: After an accepted packed data write, ready is 0 for exactly four cycles and then 1. After an accepted narrow data write, ready is 0 for exactly one cycle.
- R7: A write presented while ready is 0 is held off and is taken once ready returns. It is neither lost nor applied twice.
- R8: A write to offset 2 (control) loads the command register when the pointer is 0x06 and the read mask when the pointer is 0x04. The value comes from bits 7:0 in packed mode and from bits 31:24 in narrow mode.
- R9: A control write with any other pointer value, and any write to offset 3 (overlay), leave the command register, the read mask and the palette unchanged.
- R10: An address write between two data writes, made when the phase is not red, makes the next byte land in the red component of the new index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pack_mode | input | 1 | 1 = four bytes per data write, 0 = top byte only; change only while ready is 1 |
| bus_wr | input | 1 | Write request, taken on a clock edge where bus_ready is 1 |
| bus_off | input | 2 | Word offset: 0 address, 1 data, 2 control, 3 overlay |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | 1 when a write can be taken |
| rd_index | input | 8 | Readback index |
| rd_rgb | output | 24 | Stored entry {R,G,B} at rd_index |
| cmd_reg | output | 8 | Command register |
| read_mask | output | 8 | Read-mask register |

## Verification
A packed stream of 193 words, each holding distinct bytes, fills the whole palette and then wraps past index 255. A word-aligned slip or a phase reset at each write would place the bytes in different entries, so either shows up in the full readback. A narrow stream starting at index 250 carries junk in its low 24 bits. It separates top-byte selection from low-byte selection, and one-component writes from four-component writes, and it crosses the wrap once more. Directed sequences then measure how long ready stays low in each mode, move the address in the middle of an entry, and load the command and mask registers through matching and non-matching pointers and through overlay writes.

// File: rtl/pal_pkg.sv
package pal_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_DRAIN  = 2'd1,
        S_SINGLE = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        C_RED = 2'd0,
        C_GRN = 2'd1,
        C_BLU = 2'd2
    } comp_t;

    localparam logic [1:0] OFF_ADDR = 2'd0;
    localparam logic [1:0] OFF_DATA = 2'd1;
    localparam logic [1:0] OFF_CTRL = 2'd2;
    localparam logic [1:0] OFF_OVL  = 2'd3;

    localparam int NUM_COMP = 3;
endpackage

// File: rtl/pal_regdec.sv
module pal_regdec
    import pal_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int COMP_W = 8,
    parameter int IDX_W  = 8,
    parameter logic [COMP_W-1:0] CMD_PTR  = 8'h06,
    parameter logic [COMP_W-1:0] MASK_PTR = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              ready,
    input  logic [1:0]        off,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              pack_mode,
    output logic              acc_addr,
    output logic              acc_data,
    output logic [IDX_W-1:0]  idx_val,
    output logic [COMP_W-1:0] cmd_q,
    output logic [COMP_W-1:0] mask_q
);
    logic              take;
    logic [COMP_W-1:0] sel_byte;
    logic [COMP_W-1:0] ptr_q;

    // Packed mode takes the low byte for register values, narrow the top byte.
    assign sel_byte = pack_mode ? wdata[COMP_W-1:0] : wdata[BUS_W-1 -: COMP_W];
    assign take     = wr && ready;
    assign acc_addr = take && (off == OFF_ADDR);
    assign acc_data = take && (off == OFF_DATA);
    assign idx_val  = IDX_W'(sel_byte);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            cmd_q  <= '0;
            mask_q <= '0;
        end else if (take) begin
            unique case (off)
                OFF_ADDR: ptr_q <= sel_byte;
                OFF_CTRL: begin
                    if (ptr_q == CMD_PTR)       cmd_q  <= sel_byte;
                    else if (ptr_q == MASK_PTR) mask_q <= sel_byte;
                end
                OFF_DATA, OFF_OVL: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pal_unpack_fsm.sv
module pal_unpack_fsm
    import pal_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int COMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_data,
    input  logic              pack_mode,
    input  logic [BUS_W-1:0]  wdata,
    output logic              ready,
    output logic              commit,
    output logic [COMP_W-1:0] commit_byte
);
    localparam int LANES  = BUS_W / COMP_W;
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    seq_state_t        state_q, state_d;
    logic [BUS_W-1:0]  sreg_q;
    logic [LANE_W-1:0] lane_q;

    // State register and word shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            sreg_q  <= '0;
            lane_q  <= '0;
        end else begin
            state_q <= state_d;
            if (acc_data) begin
                sreg_q <= wdata;
                lane_q <= '0;
            end else if (state_q == S_DRAIN) begin
                sreg_q <= sreg_q << COMP_W;
                lane_q <= lane_q + 1'b1;
            end
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (acc_data) state_d = pack_mode ? S_DRAIN : S_SINGLE;
            S_DRAIN:  if (lane_q == LAST_LANE) state_d = S_IDLE;
            S_SINGLE: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ready       = (state_q == S_IDLE);
        commit      = (state_q == S_DRAIN) || (state_q == S_SINGLE);
        commit_byte = sreg_q[BUS_W-1 -: COMP_W];
    end
endmodule

// File: rtl/pal_cursor.sv
module pal_cursor
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    input  logic             advance,
    output logic [IDX_W-1:0] idx,
    output comp_t            comp
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx  <= '0;
            comp <= C_RED;
        end else if (load) begin
            idx  <= load_idx;
            comp <= C_RED;
        end else if (advance) begin
            unique case (comp)
                C_RED:   comp <= C_GRN;
                C_GRN:   comp <= C_BLU;
                C_BLU: begin
                    comp <= C_RED;
                    idx  <= idx + 1'b1;
                end
                default: comp <= C_RED;
            endcase
        end
    end
endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int COMP_W = 8,
    parameter int IDX_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [IDX_W-1:0]           w_idx,
    input  comp_t                      w_comp,
    input  logic [COMP_W-1:0]          w_byte,
    input  logic [IDX_W-1:0]           r_idx,
    output logic [NUM_COMP*COMP_W-1:0] r_rgb
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int ENT_W   = NUM_COMP * COMP_W;

    logic [ENT_W-1:0] mem_q [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
        end else if (we) begin
            unique case (w_comp)
                C_RED:   mem_q[w_idx][3*COMP_W-1 -: COMP_W] <= w_byte;
                C_GRN:   mem_q[w_idx][2*COMP_W-1 -: COMP_W] <= w_byte;
                C_BLU:   mem_q[w_idx][COMP_W-1:0]           <= w_byte;
                default: ;
            endcase
        end
    end

    assign r_rgb = mem_q[r_idx];
endmodule

// File: rtl/pal_pack_seq.sv
module pal_pack_seq
    import pal_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int COMP_W = 8,
    parameter int IDX_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pack_mode,
    input  logic                       bus_wr,
    input  logic [1:0]                 bus_off,
    input  logic [BUS_W-1:0]           bus_wdata,
    output logic                       bus_ready,
    input  logic [IDX_W-1:0]           rd_index,
    output logic [NUM_COMP*COMP_W-1:0] rd_rgb,
    output logic [COMP_W-1:0]          cmd_reg,
    output logic [COMP_W-1:0]          read_mask
);
    logic              acc_addr, acc_data, commit;
    logic [IDX_W-1:0]  idx_val, cur_idx;
    logic [COMP_W-1:0] commit_byte;
    comp_t             cur_comp;

    pal_regdec #(.BUS_W(BUS_W), .COMP_W(COMP_W), .IDX_W(IDX_W)) i_regdec (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .ready(bus_ready),
        .off(bus_off), .wdata(bus_wdata), .pack_mode(pack_mode),
        .acc_addr(acc_addr), .acc_data(acc_data), .idx_val(idx_val),
        .cmd_q(cmd_reg), .mask_q(read_mask)
    );

    pal_unpack_fsm #(.BUS_W(BUS_W), .COMP_W(COMP_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .acc_data(acc_data), .pack_mode(pack_mode),
        .wdata(bus_wdata), .ready(bus_ready), .commit(commit),
        .commit_byte(commit_byte)
    );

    pal_cursor #(.IDX_W(IDX_W)) i_cursor (
        .clk(clk), .rst_n(rst_n), .load(acc_addr), .load_idx(idx_val),
        .advance(commit), .idx(cur_idx), .comp(cur_comp)
    );

    pal_store #(.COMP_W(COMP_W), .IDX_W(IDX_W)) i_store (
        .clk(clk), .rst_n(rst_n), .we(commit), .w_idx(cur_idx),
        .w_comp(cur_comp), .w_byte(commit_byte), .r_idx(rd_index),
        .r_rgb(rd_rgb)
    );
endmodule

// File: rtl/pal_pack_seq_chk.sv
module pal_pack_seq_chk #(
    parameter int BUS_W  = 32,
    parameter int COMP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pack_mode,
    input logic              bus_wr,
    input logic [1:0]        bus_off,
    input logic              bus_ready,
    input logic [COMP_W-1:0] cmd_reg,
    input logic [COMP_W-1:0] read_mask
);
    logic take;
    assign take = bus_wr && bus_ready;

    a_r6_packed_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (take && bus_off == 2'd1 && pack_mode) |=>
            !bus_ready ##1 !bus_ready ##1 !bus_ready ##1 !bus_ready ##1 bus_ready);

    a_r6_narrow_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (take && bus_off == 2'd1 && !pack_mode) |=> !bus_ready ##1 bus_ready);

    a_r2_addr_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (take && bus_off == 2'd0) |=> bus_ready);

    a_r9_ovl_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
        (take && bus_off == 2'd3) |=> ($stable(cmd_reg) && $stable(read_mask)));

    a_r8_regs_only_on_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && bus_off == 2'd2) |=> ($stable(cmd_reg) && $stable(read_mask)));
endmodule

bind pal_pack_seq pal_pack_seq_chk #(.BUS_W(BUS_W), .COMP_W(COMP_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .pack_mode(pack_mode), .bus_wr(bus_wr),
    .bus_off(bus_off), .bus_ready(bus_ready), .cmd_reg(cmd_reg),
    .read_mask(read_mask)
);

// File: tb/test_pal_pack_seq.sv
module test_pal_pack_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pack_mode = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_off = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [7:0]  rd_index = '0;
    logic [23:0] rd_rgb;
    logic [7:0]  cmd_reg, read_mask;

    int total = 0;
    int fails = 0;

    logic [23:0] model [256];
    logic [7:0]  m_idx = '0;
    int          m_ph = 0;

    always #4 clk = ~clk;

    pal_pack_seq i_pal_pack_seq (
        .clk(clk), .rst_n(rst_n), .pack_mode(pack_mode), .bus_wr(bus_wr),
        .bus_off(bus_off), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .rd_index(rd_index), .rd_rgb(rd_rgb), .cmd_reg(cmd_reg),
        .read_mask(read_mask)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] off, input logic [31:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_off = off; bus_wdata = data;
        while (!bus_ready) @(negedge clk);
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!bus_ready) @(negedge clk);
    endtask

    task automatic mpush(input logic [7:0] b);
        case (m_ph)
            0: model[m_idx][23:16] = b;
            1: model[m_idx][15:8]  = b;
            default: model[m_idx][7:0] = b;
        endcase
        if (m_ph == 2) begin m_ph = 0; m_idx = m_idx + 8'd1; end
        else m_ph++;
    endtask

    task automatic check_pal(input string tag);
        wait_idle();
        for (int i = 0; i < 256; i++) begin
            rd_index = 8'(i);
            #1 chk(tag, {8'h0, rd_rgb}, {8'h0, model[i]});
        end
    endtask

    function automatic logic [7:0] pb(input int n);
        return 8'((n * 37 + 11) % 256);
    endfunction

    initial begin
        #(8 * 150000);
        fails++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 ready", {31'h0, bus_ready}, 32'h1);
        chk("R1 cmd", {24'h0, cmd_reg}, 32'h0);
        chk("R1 mask", {24'h0, read_mask}, 32'h0);
        check_pal("R1 palette");

        // R2 R3 R5 R7: packed stream filling the palette and wrapping
        wr(2'd0, 32'hFFFF_FF00); m_idx = 8'd0; m_ph = 0;
        for (int w = 0; w < 193; w++) begin
            logic [31:0] word;
            word = {pb(4*w), pb(4*w+1), pb(4*w+2), pb(4*w+3)};
            wr(2'd1, word);
            for (int k = 0; k < 4; k++) mpush(word[31-8*k -: 8]);
            if (w == 1) begin
                wait_idle();
                for (int e = 0; e < 3; e++) begin
                    rd_index = 8'(e);
                    #1 chk("R7 back-to-back entry", {8'h0, rd_rgb}, {8'h0, model[e]});
                end
            end
        end
        check_pal("R3 R5 packed sweep with wrap");

        // R6 packed busy window
        wr(2'd0, 32'd100); m_idx = 8'd100; m_ph = 0;
        wr(2'd1, 32'h1122_3344);
        for (int k = 0; k < 4; k++) mpush(8'(8'h11 * (k + 1)));
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk("R6 packed busy", {31'h0, bus_ready}, 32'h0);
        end
        @(negedge clk);
        chk("R6 packed ready back", {31'h0, bus_ready}, 32'h1);

        // R8 R9 packed-mode control loads
        wr(2'd0, 32'hAB00_0006); wr(2'd2, 32'h0000_0073);
        wr(2'd0, 32'hAB00_0004); wr(2'd2, 32'h0000_00FF);
        @(negedge clk);
        chk("R8 cmd packed", {24'h0, cmd_reg}, 32'h73);
        chk("R8 mask packed", {24'h0, read_mask}, 32'hFF);
        wr(2'd0, 32'h0000_0005); wr(2'd2, 32'h0000_0011);
        wr(2'd3, 32'h5555_5555);
        @(negedge clk);
        chk("R9 cmd kept", {24'h0, cmd_reg}, 32'h73);
        chk("R9 mask kept", {24'h0, read_mask}, 32'hFF);
        check_pal("R9 palette kept");

        // R10 address change mid-entry
        wr(2'd0, 32'd10); m_idx = 8'd10; m_ph = 0;
        wr(2'd1, 32'hC1C2_C3C4);
        mpush(8'hC1); mpush(8'hC2); mpush(8'hC3); mpush(8'hC4);
        wr(2'd0, 32'd20); m_idx = 8'd20; m_ph = 0;
        wr(2'd1, 32'hD1D2_D3D4);
        mpush(8'hD1); mpush(8'hD2); mpush(8'hD3); mpush(8'hD4);
        check_pal("R10 phase reset");

        // R4 R2 R5 narrow mode, top byte only, wrap from 250
        wait_idle();
        pack_mode = 1'b0;
        wr(2'd0, {8'd250, 24'h12_3456}); m_idx = 8'd250; m_ph = 0;
        for (int k = 0; k < 21; k++) begin
            logic [7:0] b;
            b = 8'(k * 29 + 5);
            wr(2'd1, {b, 24'hA5A5A5 ^ 24'(k)});
            mpush(b);
        end
        check_pal("R4 narrow stream");

        // R6 narrow busy window
        wr(2'd1, {8'h9E, 24'hFFFFFF}); mpush(8'h9E);
        @(negedge clk);
        chk("R6 narrow busy", {31'h0, bus_ready}, 32'h0);
        @(negedge clk);
        chk("R6 narrow ready back", {31'h0, bus_ready}, 32'h1);

        // R8 narrow-mode control loads
        wr(2'd0, 32'h0600_00FF); wr(2'd2, 32'h7000_00EE);
        wr(2'd0, 32'h0400_0006); wr(2'd2, 32'h0000_0077);
        @(negedge clk);
        chk("R8 cmd narrow", {24'h0, cmd_reg}, 32'h70);
        chk("R8 mask narrow", {24'h0, read_mask}, 32'h00);
        check_pal("R8 palette after control");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule